// File: doc/BRIEF.md
# Sleep-Mode Power Manager

This block lets software put the chip to sleep and brings it back when a permitted wake event arrives. Software sees eight 32-bit registers on a simple word-addressed bus. Writing a one to the force bit of the control word starts a fixed sequence. For one cycle the block latches the GPIO sleep levels and records the cause. It then holds the pins at those levels and waits in sleep. When an enabled wake input arrives, it passes through a one-cycle wake state and returns to run.

Each wake input belongs to one of two classes, set by a parameter. Inputs of the sampled class are watched during sleep. Inputs of the disabled class can never wake the block, even when software enables them. A slow-clock tick enable drives a counter that raises an oscillator-stable flag a set number of ticks after hardware reset. Reads are combinational, so data is valid in the same cycle as the read strobe.

Top module: `pmgr_top`

## Requirements
- R1: A synchronous reset clears every register. While reset is held, reads at all eight addresses return 0, and `sleep_active`, `osc_stable` and `gpio_out` are 0.
- R2: Writing a value with bit 0 set to address 0 (control) sets the force bit. `sleep_active` rises one clock edge after the write edge. A write with bit 0 clear leaves the force bit and the state unchanged.
- R3: The force bit reads back as 1 during sleep. It clears on the edge where the block returns to run, and it clears on reset.
- R4: Control bits 31:1 always read as 0. The wake-enable register (address 3) keeps only its low NW bits and the GPIO sleep-level register (address 6) keeps only its low NG bits. Their upper bits read as 0.
- R5: Status bit 0 (address 1) is set on the edge that leaves the entry state. A write of 1 to that bit clears it. A write of 0 has no effect. Setting takes priority over clearing.
- R6: The scratch register (address 2) keeps its value through a full sleep and wake sequence.
- R7: In run, `gpio_out` follows `gpio_run_out` one cycle later. On the edge that leaves the entry state, each pin with `gpio_dir`=1 takes its bit from the sleep-level register and each other pin takes its current `gpio_run_out` bit. Those values hold until one edge after the return to run.
- R8: In sleep, the block moves to wake only when `wake_in & wake_enable` is non-zero on a sampled-class bit. In the default build the sampled class is bits 3:0. `sleep_active` falls one edge after the wake edge.
- R9: `osc_stable` (also bit 0 at address 7) rises on the OSC_TICKS-th `slow_tick` after reset and stays high.
- R10: With `bus_rd` high, `bus_rdata` shows the addressed register in the same cycle. With `bus_rd` low it is 0.
- R11: The configuration register (address 4) and the PLL configuration register (address 5) are plain 32-bit read/write storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| slow_tick | input | 1 | One-cycle enable per slow-oscillator period |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| wake_in | input | NW | Wake event inputs |
| gpio_dir | input | NG | Pin direction, 1 = output |
| gpio_run_out | input | NG | Pin levels driven while running |
| gpio_out | output | NG | Pin levels to the pads |
| sleep_active | output | 1 | High in entry, sleep and wake states |
| osc_stable | output | 1 | Oscillator has settled |

## Verification
Read data is due in the strobe cycle, so the bench samples it 1 ns after driving the strobe and before the next edge. A control write lands on edge E. `sleep_active` is due after E+1, and the latched pin levels and the cause bit are due after E+2. A qualifying wake input drives the block into wake on the next edge and back to run on the edge after that, with the pins released one edge later still. All inputs change on falling edges, and each check is placed at the falling edge that follows the counted number of rising edges. The oscillator flag is checked one tick before and exactly at the configured count.

// File: rtl/pmgr_pkg.sv
package pmgr_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ENTER = 2'd1,
    ST_SLEEP = 2'd2,
    ST_WAKE  = 2'd3
  } pm_state_e;

  localparam int          REG_AW = 3;
  localparam logic [2:0]  A_CTRL = 3'd0;
  localparam logic [2:0]  A_STAT = 3'd1;
  localparam logic [2:0]  A_SCR  = 3'd2;
  localparam logic [2:0]  A_WEN  = 3'd3;
  localparam logic [2:0]  A_CFG  = 3'd4;
  localparam logic [2:0]  A_PLL  = 3'd5;
  localparam logic [2:0]  A_GSS  = 3'd6;
  localparam logic [2:0]  A_OSC  = 3'd7;
endpackage

// File: rtl/pmgr_osc_timer.sv
module pmgr_osc_timer #(
  parameter int TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic slow_tick,
  output logic stable_q
);
  localparam int CW = $clog2(TICKS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else if (slow_tick && !stable_q) begin
      if (cnt_q == CW'(TICKS - 1)) stable_q <= 1'b1;
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pmgr_seq.sv
module pmgr_seq
  import pmgr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      force_req,
  input  logic      wake_hit,
  output pm_state_e state_q,
  output logic      active_q
);
  pm_state_e nxt;

  always_comb begin
    nxt = state_q;
    case (state_q)
      ST_RUN:   if (force_req) nxt = ST_ENTER;
      ST_ENTER: nxt = ST_SLEEP;
      ST_SLEEP: if (wake_hit) nxt = ST_WAKE;
      ST_WAKE:  nxt = ST_RUN;
      default:  nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_RUN;
      active_q <= 1'b0;
    end else begin
      state_q  <= nxt;
      active_q <= (nxt != ST_RUN);
    end
  end
endmodule

// File: rtl/pmgr_gpio_hold.sv
module pmgr_gpio_hold
  import pmgr_pkg::*;
#(
  parameter int NG = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  pm_state_e     state,
  input  logic [NG-1:0] dir,
  input  logic [NG-1:0] run_lvl,
  input  logic [NG-1:0] sleep_lvl,
  output logic [NG-1:0] out_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
    end else begin
      case (state)
        ST_ENTER:          out_q <= (sleep_lvl & dir) | (run_lvl & ~dir);
        ST_SLEEP, ST_WAKE: out_q <= out_q;
        default:           out_q <= run_lvl;
      endcase
    end
  end
endmodule

// File: rtl/pmgr_top.sv
module pmgr_top
  import pmgr_pkg::*;
#(
  parameter int            NW           = 8,
  parameter int            NG           = 16,
  parameter logic [NW-1:0] WAKE_SAMPLED = {NW{1'b1}} >> (NW / 2),
  parameter int            OSC_TICKS    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slow_tick,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [2:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [NW-1:0] wake_in,
  input  logic [NG-1:0] gpio_dir,
  input  logic [NG-1:0] gpio_run_out,
  output logic [NG-1:0] gpio_out,
  output logic          sleep_active,
  output logic          osc_stable
);
  pm_state_e     st_q;
  logic          force_q;
  logic          cause_q;
  logic [31:0]   scratch_q, cfg_q, pll_q;
  logic [NW-1:0] wen_q;
  logic [NG-1:0] gss_q;
  logic [NW-1:0] wake_qual;
  logic          wake_hit;

  // Per-bit wake qualification: disabled-class bits are tied off.
  for (genvar i = 0; i < NW; i++) begin : g_wake
    if (WAKE_SAMPLED[i]) begin : g_smp
      assign wake_qual[i] = wake_in[i] & wen_q[i];
    end else begin : g_off
      assign wake_qual[i] = 1'b0;
    end
  end
  assign wake_hit = |wake_qual;

  wire wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  wire wr_stat = bus_wr && (bus_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      force_q   <= 1'b0;
      cause_q   <= 1'b0;
      scratch_q <= '0;
      cfg_q     <= '0;
      pll_q     <= '0;
      wen_q     <= '0;
      gss_q     <= '0;
    end else begin
      // Exit clear wins over a set in the same cycle.
      if (st_q == ST_WAKE)            force_q <= 1'b0;
      else if (wr_ctrl && bus_wdata[0]) force_q <= 1'b1;

      if (st_q == ST_ENTER)           cause_q <= 1'b1;
      else if (wr_stat && bus_wdata[0]) cause_q <= 1'b0;

      if (bus_wr) begin
        case (bus_addr)
          A_SCR:   scratch_q <= bus_wdata;
          A_WEN:   wen_q     <= bus_wdata[NW-1:0];
          A_CFG:   cfg_q     <= bus_wdata;
          A_PLL:   pll_q     <= bus_wdata;
          A_GSS:   gss_q     <= bus_wdata[NG-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_CTRL:  bus_rdata = 32'(force_q);
        A_STAT:  bus_rdata = 32'(cause_q);
        A_SCR:   bus_rdata = scratch_q;
        A_WEN:   bus_rdata = 32'(wen_q);
        A_CFG:   bus_rdata = cfg_q;
        A_PLL:   bus_rdata = pll_q;
        A_GSS:   bus_rdata = 32'(gss_q);
        default: bus_rdata = 32'(osc_stable);
      endcase
    end
  end

  pmgr_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .force_req (force_q),
    .wake_hit  (wake_hit),
    .state_q   (st_q),
    .active_q  (sleep_active)
  );

  pmgr_gpio_hold #(.NG(NG)) u_gpio (
    .clk       (clk),
    .rst       (rst),
    .state     (st_q),
    .dir       (gpio_dir),
    .run_lvl   (gpio_run_out),
    .sleep_lvl (gss_q),
    .out_q     (gpio_out)
  );

  pmgr_osc_timer #(.TICKS(OSC_TICKS)) u_osc (
    .clk       (clk),
    .rst       (rst),
    .slow_tick (slow_tick),
    .stable_q  (osc_stable)
  );
endmodule

// File: rtl/pmgr_chk.sv
module pmgr_chk
  import pmgr_pkg::*;
#(
  parameter int NG = 16
) (
  input logic          clk,
  input logic          rst,
  input pm_state_e     st,
  input logic          force_q,
  input logic          cause_q,
  input logic          wake_hit,
  input logic          sleep_active,
  input logic          osc_stable,
  input logic [NG-1:0] gpio_out,
  input logic          bus_rd,
  input logic [2:0]    bus_addr,
  input logic [31:0]   bus_rdata
);
  p_ctrl_rsvd_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_CTRL) |-> (bus_rdata[31:1] == 31'd0));

  p_entry_needs_force_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep_active) |-> $past(force_q));

  p_force_clear_exit_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep_active) |-> !force_q);

  p_cause_on_entry_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ENTER) |=> cause_q);

  p_pins_held_r7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SLEEP) |=> $stable(gpio_out));

  p_no_wake_unqualified_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SLEEP && !wake_hit) |=> (st == ST_SLEEP));

  p_osc_stays_r9: assert property (@(posedge clk) disable iff (rst)
    !$fell(osc_stable));
endmodule

bind pmgr_top pmgr_chk #(.NG(NG)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .st           (st_q),
  .force_q      (force_q),
  .cause_q      (cause_q),
  .wake_hit     (wake_hit),
  .sleep_active (sleep_active),
  .osc_stable   (osc_stable),
  .gpio_out     (gpio_out),
  .bus_rd       (bus_rd),
  .bus_addr     (bus_addr),
  .bus_rdata    (bus_rdata)
);

// File: tb/sim_pmgr_top.sv
`timescale 1ns/1ps
module sim_pmgr_top;
  localparam int NW = 8;
  localparam int NG = 16;
  localparam int OSC_TICKS = 16;
  localparam logic [NW-1:0] SAMPLED = 8'h0F;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          slow_tick = 1'b0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NW-1:0] wake_in = '0;
  logic [NG-1:0] gpio_dir = '0, gpio_run_out = '0;
  logic [NG-1:0] gpio_out;
  logic          sleep_active, osc_stable;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] model [8];

  always #2.5 clk = ~clk;

  pmgr_top u0 (
    .clk(clk), .rst(rst), .slow_tick(slow_tick),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wake_in(wake_in), .gpio_dir(gpio_dir), .gpio_run_out(gpio_run_out),
    .gpio_out(gpio_out), .sleep_active(sleep_active), .osc_stable(osc_stable)
  );

  function automatic logic [31:0] keep_mask(input int a);
    case (a)
      3: return 32'(8'hFF);
      6: return 32'(16'hFFFF);
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [NG-1:0] pin_mix(input logic [NG-1:0] lvl,
                                            input logic [NG-1:0] dir,
                                            input logic [NG-1:0] run);
    return (lvl & dir) | (run & ~dir);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 3'(a);
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); slow_tick = 1'b1;
    @(negedge clk); slow_tick = 1'b0;
  endtask

  // Enter sleep and check entry timing and latched pins; returns at negedge after SLEEP.
  task automatic enter_sleep(output logic [NG-1:0] held);
    wr(0, 32'h1);
    check("R2 active not yet", 32'(sleep_active), 32'd0);
    @(negedge clk);
    check("R2 active after entry", 32'(sleep_active), 32'd1);
    held = pin_mix(model[6][NG-1:0], gpio_dir, gpio_run_out);
    @(negedge clk);
    check("R7 pins latched", 32'(gpio_out), 32'(held));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [NG-1:0] held;
    void'($urandom(32'd7));
    for (int i = 0; i < 8; i++) model[i] = '0;

    // R1 reset state
    repeat (3) @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      @(negedge clk); bus_rd = 1'b1; bus_addr = 3'(a);
      #1 check("R1 reset read", bus_rdata, 32'd0);
      bus_rd = 1'b0;
    end
    check("R1 active", 32'(sleep_active), 32'd0);
    check("R1 osc", 32'(osc_stable), 32'd0);
    check("R1 gpio", 32'(gpio_out), 32'd0);
    @(negedge clk); rst = 1'b0;

    // R10 read strobe low gives zero
    wr(2, 32'h1357_9BDF); model[2] = 32'h1357_9BDF;
    @(negedge clk); bus_addr = 3'd2; #1 check("R10 no strobe", bus_rdata, 32'd0);
    rd(2, d); check("R10 same-cycle read", d, model[2]);

    // R9 oscillator count
    for (int i = 0; i < OSC_TICKS - 1; i++) tick();
    check("R9 before count", 32'(osc_stable), 32'd0);
    tick();
    check("R9 at count", 32'(osc_stable), 32'd1);
    rd(7, d); check("R9 reg", d, 32'd1);

    // R2/R4 control writes without bit 0
    wr(0, 32'hFFFF_FFFE);
    @(negedge clk);
    check("R2 zero write no sleep", 32'(sleep_active), 32'd0);
    rd(0, d); check("R4 ctrl reserved", d, 32'd0);
    wr(1, 32'hFFFF_FFFF);
    rd(1, d); check("R5 status idle", d, 32'd0);

    // R11/R4 random register traffic
    for (int i = 0; i < 60; i++) begin
      int a;
      int pick;
      logic [31:0] v;
      pick = int'($urandom % 5);
      a = (pick == 0) ? 2 : (pick == 1) ? 3 : (pick == 2) ? 4 : (pick == 3) ? 5 : 6;
      v = $urandom;
      wr(a, v); model[a] = v & keep_mask(a);
      pick = int'($urandom % 5);
      a = (pick == 0) ? 2 : (pick == 1) ? 3 : (pick == 2) ? 4 : (pick == 3) ? 5 : 6;
      rd(a, d);
      check((a == 4 || a == 5) ? "R11 rw" : "R4 rw masked", d, model[a]);
    end

    // Directed sleep cycle: R3 R5 R6 R7 R8
    model[3] = 32'h33; wr(3, model[3]);        // enables bits 0,1 (sampled) and 4,5 (disabled class)
    model[6] = 32'hA5C3; wr(6, model[6]);
    model[2] = 32'hDEAD_BEEF; wr(2, model[2]);
    gpio_dir = 16'h0FF0; gpio_run_out = 16'h1234;
    @(negedge clk);
    check("R7 run follows", 32'(gpio_out), 32'h1234);
    enter_sleep(held);
    gpio_run_out = 16'hFFFF;
    rd(1, d); check("R5 cause set", d, 32'd1);
    rd(0, d); check("R3 force reads 1", d, 32'd1);
    check("R7 held", 32'(gpio_out), 32'(held));
    wake_in = 8'h10;
    repeat (3) @(negedge clk);
    check("R8 disabled class ignored", 32'(sleep_active), 32'd1);
    wake_in = 8'h04;
    repeat (3) @(negedge clk);
    check("R8 unenabled ignored", 32'(sleep_active), 32'd1);
    wake_in = 8'h02;
    @(negedge clk);
    check("R8 wake state active", 32'(sleep_active), 32'd1);
    wake_in = '0;
    @(negedge clk);
    check("R8 back to run", 32'(sleep_active), 32'd0);
    check("R7 held one more", 32'(gpio_out), 32'(held));
    @(negedge clk);
    check("R7 released", 32'(gpio_out), 32'hFFFF);
    rd(0, d); check("R3 force cleared", d, 32'd0);
    rd(2, d); check("R6 scratch kept", d, 32'hDEAD_BEEF);
    wr(1, 32'h0); rd(1, d); check("R5 zero write", d, 32'd1);
    wr(1, 32'h1); rd(1, d); check("R5 w1c", d, 32'd0);

    // Random sleep cycles: R7 R8
    for (int n = 0; n < 8; n++) begin
      bit woke;
      model[3] = 32'($urandom & 32'hFF) | 32'h1; wr(3, model[3]);
      model[6] = 32'($urandom & 32'hFFFF);        wr(6, model[6]);
      gpio_dir = NG'($urandom); gpio_run_out = NG'($urandom);
      @(negedge clk);
      enter_sleep(held);
      woke = 0;
      for (int k = 0; k < 30 && !woke; k++) begin
        logic [NW-1:0] w;
        w = (k == 29) ? 8'h01 : NW'($urandom);
        wake_in = w;
        @(negedge clk);
        check("R8 active during wake/sleep", 32'(sleep_active), 32'd1);
        woke = |(w & model[3][NW-1:0] & SAMPLED);
      end
      wake_in = '0;
      @(negedge clk);
      check("R8 random wake exit", 32'(sleep_active), 32'd0);
      check("R7 random hold", 32'(gpio_out), 32'(held));
    end

    // Reset during sleep: R1 R3
    enter_sleep(held);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rd(0, d); check("R3 reset clears force", d, 32'd0);
    rd(3, d); check("R1 reset clears enable", d, 32'd0);
    check("R1 reset active", 32'(sleep_active), 32'd0);
    check("R1 reset osc", 32'(osc_stable), 32'd0);
    @(negedge clk); rst = 1'b0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule